// File: doc/BRIEF.md
# Double-Buffered Serial Character Transmitter

This block turns bytes written by a host into serial frames on a single line output. A one-character holding register sits in front of a frame serializer. The host can therefore load the next byte while the current one is still shifting out, and the two frames follow each other with no idle gap. Bit timing comes from a one-cycle pulse, `txc_fall`, that marks each falling edge of the transmit clock. The serializer changes the line only on those pulses.

Two framings are supported. Asynchronous framing sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and a stop period. Each bit lasts 1, 16 or 64 transmit-clock pulses. Synchronous framing sends the data bits and the optional parity bit at one pulse per bit. When no data is waiting, it fills the line with one or two programmed sync characters. Transmission starts only while `tx_en` is high and `cts_n` is low. A frame that is already in progress always completes.

Top module: `frame_tx`

## Requirements
- R1: Reset conditions. After a synchronous reset, `txd` is 1 (mark), `rdy_stat` is 1 and `empty` is 1. While idle with no character to send, `txd` stays at 1.
- R2: Break. While `brk` is 1, `txd` reads 0 whatever the serializer is doing.
- R3: Ready outputs. `rdy_pin` is 1 only when the holding register is free, `tx_en` is 1 and `cts_n` is 0. `rdy_stat` is 1 exactly when the holding register is free, and it ignores `tx_en` and `cts_n`.
- R4: Effect of a write. A cycle with `wr_stb` high fills the holding register. From the next cycle, `rdy_stat`, `rdy_pin` and `empty` read 0.
- R5: Disable. While `tx_en` is 0 or `cts_n` is 1, no new frame starts, but a frame in progress completes. A byte written while disabled stays in the holding register, so `empty` stays 0 and `txd` stays 1. The byte is sent once the transmitter is enabled again.
- R6: Synchronous fill. In synchronous mode (`cfg_sync`=1), when enabled with nothing in the holding register, the serializer sends `sync_a` as a character. With `cfg_two_sync`=1 it sends `sync_a` and `sync_b` alternately, and each run of fill restarts at `sync_a`. `empty` reads 1 while sync characters are sent.
- R7: Bit timing. `txd` changes only in the cycle after a `txc_fall` pulse. In asynchronous mode each bit lasts 1, 16 or 64 pulses for `cfg_div` = 0, 1 or 2/3. In synchronous mode each bit lasts 1 pulse.
- R8: Character layout. `cfg_len` = 0..3 selects 5..8 data bits, sent least significant bit first. In asynchronous mode they are preceded by one start bit at 0.
- R9: Parity. With `cfg_par_en`=1, a parity bit follows the data bits. `cfg_par_even`=1 makes the total count of ones in the data and parity bits even. `cfg_par_even`=0 makes it odd.
- R10: Stop period. `cfg_stop` selects the asynchronous stop period: 2 gives 1.5 bits, 3 gives 2 bits, and 0 or 1 give 1 bit. At divisors 16 and 64, 1.5 bits last 24 and 96 pulses. At divisor 1, 1.5 bits last 2 pulses.
- R11: Back-to-back frames. A byte waiting in the holding register starts on the same pulse that ends the previous frame, and the holding register is then free for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | One-cycle byte write strobe |
| wr_data | input | CHAR_W | Byte written by the host |
| txc_fall | input | 1 | One-cycle pulse per transmit-clock falling edge |
| cfg_sync | input | 1 | 1 = synchronous framing |
| cfg_div | input | 2 | Asynchronous bit length: 0 = 1, 1 = 16, 2/3 = 64 pulses |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop | input | 2 | Stop period: 0/1 = 1 bit, 2 = 1.5 bits, 3 = 2 bits |
| cfg_two_sync | input | 1 | Alternate two sync characters |
| sync_a | input | CHAR_W | First sync character |
| sync_b | input | CHAR_W | Second sync character |
| tx_en | input | 1 | Transmit enable |
| brk | input | 1 | Force the line low |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line output |
| rdy_pin | output | 1 | Ready, gated by enable and clear to send |
| rdy_stat | output | 1 | Ready, holding-register space only |
| empty | output | 1 | No data character held or in progress |

## Verification
A holding-register flag stuck at the wrong value shows at `rdy_stat` and `empty` in the cycle after the write or the take. It also shows at `txd` when a frame is repeated or lost one pulse later. A wrong bit counter or duration counter moves a `txd` transition earlier or later by at least one `txc_fall` pulse, so the line differs within the affected bit. A wrong sync-select or parity bit shows at `txd` within the next character time. A reference model compared on every clock therefore finds any such fault within one frame.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BITS = 2'd1,
    PH_STOP = 2'd2
  } tx_phase_e;

  typedef struct packed {
    logic       sync_mode;
    logic [1:0] div_sel;
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_even;
    logic [1:0] stop_sel;
    logic       two_sync;
  } tx_cfg_t;

endpackage

// File: rtl/frame_tx_fmt.sv
module frame_tx_fmt #(
  parameter int CHAR_W  = 8,
  parameter int FRAME_W = CHAR_W + 2,
  parameter int NB_W    = $clog2(FRAME_W + 1)
) (
  input  logic [CHAR_W-1:0]  ch,
  input  logic [1:0]         len_sel,
  input  logic               par_en,
  input  logic               par_even,
  input  logic               async_mode,
  output logic [FRAME_W-1:0] frame,
  output logic [NB_W-1:0]    nbits
);

  localparam int MIN_LEN = CHAR_W - 3;

  int          n;
  int          off;
  logic        ones_par;
  logic        par_bit;

  always_comb begin
    n        = MIN_LEN + int'(len_sel);
    off      = async_mode ? 1 : 0;
    ones_par = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n) ones_par = ones_par ^ ch[i];
    end
    par_bit = ones_par ^ ~par_even;
    frame   = '1;
    if (async_mode) frame[0] = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < n) begin
        if (async_mode) frame[i+1] = ch[i];
        else            frame[i]   = ch[i];
      end
    end
    for (int j = 0; j < FRAME_W; j++) begin
      if (par_en && j == n + off) frame[j] = par_bit;
    end
    nbits = NB_W'(off + n + (par_en ? 1 : 0));
  end

endmodule

// File: rtl/frame_tx_hold.sv
module frame_tx_hold #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_stb) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R4: a write always leaves the register occupied
  p_write_fills_r4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> full);

  // R11: the serializer only consumes an occupied register
  p_take_needs_full_r11: assert property (@(posedge clk) disable iff (rst)
    take |-> full);

endmodule

// File: rtl/frame_tx_ser.sv
module frame_tx_ser
  import frame_tx_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              active,
  input  tx_cfg_t           cfg,
  input  logic              hold_full,
  input  logic [CHAR_W-1:0] hold_data,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  output logic              take,
  output logic              line,
  output logic              data_busy
);

  localparam int FRAME_W = CHAR_W + 2;
  localparam int NB_W    = $clog2(FRAME_W + 1);
  localparam int CNT_W   = $clog2(2 * DIV_HI + 1);

  tx_phase_e           phase;
  logic [FRAME_W-1:0]  sh;
  logic [NB_W-1:0]     bits_left;
  logic [CNT_W-1:0]    cnt;
  logic                sync_sel;

  logic [CNT_W-1:0]    bit_clk;
  logic [CNT_W-1:0]    stop_clk;
  logic                finish;
  logic                go;
  logic                fill;
  logic [CHAR_W-1:0]   sel_char;
  logic [FRAME_W-1:0]  frame;
  logic [NB_W-1:0]     nbits;
  int                  b_len;
  int                  s_len;

  always_comb begin
    if (cfg.sync_mode)           b_len = 1;
    else if (cfg.div_sel == 2'd0) b_len = 1;
    else if (cfg.div_sel == 2'd1) b_len = DIV_MID;
    else                          b_len = DIV_HI;
    case (cfg.stop_sel)
      2'd2:    s_len = (b_len == 1) ? 2 : (b_len * 3) / 2;
      2'd3:    s_len = 2 * b_len;
      default: s_len = b_len;
    endcase
    bit_clk  = CNT_W'(b_len);
    stop_clk = CNT_W'(s_len);
  end

  assign finish = tick && (cnt == '0) &&
                  ((phase == PH_BITS && bits_left == '0 && cfg.sync_mode) ||
                   phase == PH_STOP);
  assign go       = tick && (phase == PH_IDLE || finish);
  assign take     = go && active && hold_full;
  assign fill     = go && active && !hold_full && cfg.sync_mode;
  assign sel_char = take ? hold_data : ((sync_sel && cfg.two_sync) ? sync_b : sync_a);

  frame_tx_fmt #(.CHAR_W(CHAR_W)) u_fmt (
    .ch        (sel_char),
    .len_sel   (cfg.len_sel),
    .par_en    (cfg.par_en),
    .par_even  (cfg.par_even),
    .async_mode(!cfg.sync_mode),
    .frame     (frame),
    .nbits     (nbits)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      line      <= 1'b1;
      sh        <= '1;
      bits_left <= '0;
      cnt       <= '0;
      sync_sel  <= 1'b0;
      data_busy <= 1'b0;
    end else if (tick) begin
      if (go) begin
        if (take || fill) begin
          phase     <= PH_BITS;
          line      <= frame[0];
          sh        <= {1'b1, frame[FRAME_W-1:1]};
          bits_left <= nbits - 1'b1;
          cnt       <= bit_clk - 1'b1;
          data_busy <= take;
          sync_sel  <= take ? 1'b0 : (cfg.two_sync ? ~sync_sel : 1'b0);
        end else begin
          phase     <= PH_IDLE;
          line      <= 1'b1;
          data_busy <= 1'b0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (phase == PH_BITS) begin
        if (bits_left != '0) begin
          line      <= sh[0];
          sh        <= {1'b1, sh[FRAME_W-1:1]};
          bits_left <= bits_left - 1'b1;
          cnt       <= bit_clk - 1'b1;
        end else begin
          phase <= PH_STOP;
          line  <= 1'b1;
          cnt   <= stop_clk - 1'b1;
        end
      end
    end
  end

  // R7: the line only moves on a transmit-clock pulse
  p_line_waits_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(line));

  // R8: an asynchronous frame opens with a low start bit
  p_start_low_r8: assert property (@(posedge clk) disable iff (rst)
    ((take || fill) && !cfg.sync_mode) |=> !line);

  // R5: nothing starts from idle while blocked
  p_blocked_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_IDLE && !active) |=> (phase == PH_IDLE && line));

  // R6: data marked in progress only while a frame runs
  p_busy_in_frame_r6: assert property (@(posedge clk) disable iff (rst)
    data_busy |-> (phase != PH_IDLE));

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              txc_fall,
  input  logic              cfg_sync,
  input  logic [1:0]        cfg_div,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_two_sync,
  input  logic [CHAR_W-1:0] sync_a,
  input  logic [CHAR_W-1:0] sync_b,
  input  logic              tx_en,
  input  logic              brk,
  input  logic              cts_n,
  output logic              txd,
  output logic              rdy_pin,
  output logic              rdy_stat,
  output logic              empty
);

  tx_cfg_t           cfg;
  logic              active;
  logic              take;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              line;
  logic              data_busy;

  assign cfg = '{sync_mode: cfg_sync, div_sel: cfg_div, len_sel: cfg_len,
                 par_en: cfg_par_en, par_even: cfg_par_even,
                 stop_sel: cfg_stop, two_sync: cfg_two_sync};
  assign active = tx_en && !cts_n;

  frame_tx_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .take   (take),
    .full   (hold_full),
    .data   (hold_data)
  );

  frame_tx_ser #(.CHAR_W(CHAR_W), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .tick     (txc_fall),
    .active   (active),
    .cfg      (cfg),
    .hold_full(hold_full),
    .hold_data(hold_data),
    .sync_a   (sync_a),
    .sync_b   (sync_b),
    .take     (take),
    .line     (line),
    .data_busy(data_busy)
  );

  assign txd      = line & ~brk;
  assign rdy_stat = ~hold_full;
  assign rdy_pin  = ~hold_full & active;
  assign empty    = ~hold_full & ~data_busy;

  // R5: a blocked transmitter never consumes the holding register
  p_no_take_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    (cts_n || !tx_en) |-> !take);

  // R11: a consumed byte frees the register unless rewritten
  p_take_frees_r11: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_stb) |=> rdy_stat);

endmodule

// File: tb/frame_tx_tb.sv
module frame_tx_tb;

  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       txc_fall = 1'b0;
  logic       cfg_sync = 1'b0;
  logic [1:0] cfg_div = 2'd1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic [1:0] cfg_stop = 2'd1;
  logic       cfg_two_sync = 1'b0;
  logic [7:0] sync_a = 8'h16;
  logic [7:0] sync_b = 8'h29;
  logic       tx_en = 1'b0;
  logic       brk = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd, rdy_pin, rdy_stat, empty;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  int lv[$];
  int du[$];
  int rem = 0;
  int m_line = 1;
  int m_full = 0;
  int m_hd = 0;
  int m_busy = 0;
  int m_ss = 0;

  always #(CLK_PER/2) clk = ~clk;

  frame_tx u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .txc_fall(txc_fall), .cfg_sync(cfg_sync), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop(cfg_stop), .cfg_two_sync(cfg_two_sync), .sync_a(sync_a),
    .sync_b(sync_b), .tx_en(tx_en), .brk(brk), .cts_n(cts_n),
    .txd(txd), .rdy_pin(rdy_pin), .rdy_stat(rdy_stat), .empty(empty)
  );

  function automatic void build(int ch);
    int d, n, ones, stp;
    d = cfg_sync ? 1 : (cfg_div == 0 ? 1 : (cfg_div == 1 ? 16 : 64));
    n = 5 + int'(cfg_len);
    ones = 0;
    if (!cfg_sync) begin lv.push_back(0); du.push_back(d); end
    for (int i = 0; i < n; i++) begin
      lv.push_back((ch >> i) & 1);
      du.push_back(d);
      ones += (ch >> i) & 1;
    end
    if (cfg_par_en) begin
      lv.push_back(cfg_par_even ? (ones % 2) : 1 - (ones % 2));
      du.push_back(d);
    end
    if (!cfg_sync) begin
      if (cfg_stop == 2) stp = (d == 1) ? 2 : d * 3 / 2;
      else if (cfg_stop == 3) stp = 2 * d;
      else stp = d;
      lv.push_back(1);
      du.push_back(stp);
    end
    m_line = lv[0];
    rem = du[0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      lv.delete(); du.delete();
      rem = 0; m_line = 1; m_full = 0; m_hd = 0; m_busy = 0; m_ss = 0;
    end else begin
      if (txc_fall) begin
        int need;
        need = 0;
        if (lv.size() == 0) need = 1;
        else begin
          rem--;
          if (rem == 0) begin
            void'(lv.pop_front()); void'(du.pop_front());
            if (lv.size() == 0) need = 1;
            else begin m_line = lv[0]; rem = du[0]; end
          end
        end
        if (need) begin
          if (m_full && tx_en && !cts_n) begin
            build(m_hd); m_full = 0; m_busy = 1; m_ss = 0;
          end else if (cfg_sync && tx_en && !cts_n) begin
            build((m_ss && cfg_two_sync) ? int'(sync_b) : int'(sync_a));
            m_busy = 0;
            m_ss = cfg_two_sync ? 1 - m_ss : 0;
          end else begin
            m_busy = 0; m_line = 1;
          end
        end
      end
      if (wr_stb) begin m_full = 1; m_hd = int'(wr_data); end
    end
  end

  // per-cycle comparison against the model (requirement tag of the running scenario)
  always @(negedge clk) begin
    if (!rst && !done) begin
      int e_txd, e_pin, e_stat, e_emp;
      e_txd  = brk ? 0 : m_line;
      e_stat = !m_full;
      e_pin  = !m_full && tx_en && !cts_n;
      e_emp  = !m_full && !m_busy;
      total++;
      if (int'(txd) != e_txd || int'(rdy_pin) != e_pin ||
          int'(rdy_stat) != e_stat || int'(empty) != e_emp) begin
        bad++;
        $display("FAIL %s t=%0t actual txd/pin/stat/empty=%0d%0d%0d%0d expected=%0d%0d%0d%0d",
                 cur_req, $time, txd, rdy_pin, rdy_stat, empty, e_txd, e_pin, e_stat, e_emp);
      end
    end
  end

  // transmit clock: one pulse every second core cycle
  initial begin
    int k;
    k = 0;
    forever begin
      @(posedge clk); #2;
      k++;
      txc_fall = (k % 2 == 0);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int b);
    @(posedge clk); #2;
    wr_stb = 1'b1; wr_data = 8'(b);
    @(posedge clk); #2;
    wr_stb = 1'b0;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while ((m_full || m_busy || lv.size() != 0) && n < 20000) begin
      step(1); n++;
    end
    step(4);
  endtask

  task automatic wait_ready();
    int n;
    n = 0;
    while (m_full && n < 20000) begin step(1); n++; end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(1);
    @(negedge clk);
    // R1 reset values
    chk(txd == 1'b1, "R1", int'(txd), 1);
    chk(rdy_stat == 1'b1, "R1", int'(rdy_stat), 1);
    chk(empty == 1'b1, "R1", int'(empty), 1);
    chk(rdy_pin == 1'b0, "R3", int'(rdy_pin), 0);

    // R4 write while disabled clears ready and empty next cycle; R5 byte held
    cur_req = "R4";
    wr(8'h5A);
    @(negedge clk);
    chk(rdy_stat == 1'b0, "R4", int'(rdy_stat), 0);
    chk(empty == 1'b0, "R4", int'(empty), 0);
    cur_req = "R5";
    step(300);
    @(negedge clk);
    chk(txd == 1'b1, "R5", int'(txd), 1);
    chk(empty == 1'b0, "R5", int'(empty), 0);
    tx_en = 1'b1;
    wait_idle();

    // R7 R8 x16, 8 bits, no parity, 1 stop; R11 back to back
    cur_req = "R11";
    wr(8'hA5);
    wait_ready();
    wr(8'h3C);
    wait_idle();

    // R9 R10 x1, 5 bits, odd parity, 1.5 stop sent as 2
    cur_req = "R10";
    cfg_div = 2'd0; cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b0; cfg_stop = 2'd2;
    wr(8'h13);
    wait_ready();
    wr(8'h0E);
    wait_idle();

    // R10 x64, 7 bits, even parity, 1.5 stop = 96 pulses
    cur_req = "R10";
    cfg_div = 2'd2; cfg_len = 2'd2; cfg_par_even = 1'b1;
    wr(8'h6B);
    wait_ready();
    wr(8'h01);
    wait_idle();

    // R9 x16, 6 bits, even parity, 2 stop
    cur_req = "R9";
    cfg_div = 2'd1; cfg_len = 2'd1; cfg_stop = 2'd3;
    wr(8'h2D);
    wait_idle();

    // R5 disable mid-frame: frame completes, later write held
    cur_req = "R5";
    cfg_par_en = 1'b0; cfg_stop = 2'd1; cfg_len = 2'd3;
    wr(8'hC3);
    step(30);
    tx_en = 1'b0;
    wait_idle();
    wr(8'h77);
    step(200);
    @(negedge clk);
    chk(txd == 1'b1, "R5", int'(txd), 1);
    chk(empty == 1'b0, "R5", int'(empty), 0);
    tx_en = 1'b1;
    wait_idle();

    // R3 clear-to-send gates the pin only
    cur_req = "R3";
    cts_n = 1'b1;
    step(2);
    @(negedge clk);
    chk(rdy_pin == 1'b0, "R3", int'(rdy_pin), 0);
    chk(rdy_stat == 1'b1, "R3", int'(rdy_stat), 1);
    wr(8'h99);
    step(100);
    @(negedge clk);
    chk(txd == 1'b1, "R5", int'(txd), 1);
    cts_n = 1'b0;
    wait_idle();

    // R2 break during a frame
    cur_req = "R2";
    wr(8'hF0);
    step(20);
    brk = 1'b1;
    step(40);
    @(negedge clk);
    chk(txd == 1'b0, "R2", int'(txd), 0);
    brk = 1'b0;
    wait_idle();

    // R6 synchronous fill with two sync characters, 5 bits + parity
    cur_req = "R6";
    tx_en = 1'b0;
    step(2);
    cfg_sync = 1'b1; cfg_two_sync = 1'b1; cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
    step(2);
    tx_en = 1'b1;
    step(40);
    @(negedge clk);
    chk(empty == 1'b1, "R6", int'(empty), 1);
    cur_req = "R8";
    wr(8'h0B);
    wait_ready();
    wr(8'h14);
    step(60);
    cur_req = "R6";
    cfg_two_sync = 1'b0;
    step(40);
    @(negedge clk);
    chk(empty == 1'b1, "R6", int'(empty), 1);
    tx_en = 1'b0;
    wait_idle();
    @(negedge clk);
    chk(txd == 1'b1, "R1", int'(txd), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule